// File: doc/BRIEF.md
# In-Flight Line Request Tracker

This block sits between a processor-side request port and the command queue of a cache controller. It records each memory request that is in flight for a cache line. Loads and instruction fetches go in one small associative table. Stores and every atomic or locked kind go in a second table. Both tables are keyed by line address.

A request is refused when:
- its bytes would cross a line boundary,
- another request for the same line is already held in either table, or
- the outstanding limit or the target table is exhausted.

A refused request gets a status code and leaves the tracker unchanged. An accepted request gets a fresh sequence number, and the block forwards it as a cache command in the same cycle. The command uses one shared atomic code for all read-modify-write and locked kinds.

A single line reservation links a locked read to a later locked write. The reservation is set when the locked read completes. The locked write is allowed only while the reservation covers its line, and accepting it consumes the reservation. Completions name a table and a line. They free the entry and echo its sequence number, or flag an error when nothing matches. An age monitor compares each live entry's issue time with a free-running cycle counter and latches a deadlock flag.

The request side is valid/ready. `req_ready` simply mirrors `cmd_ready`, so a stalled command queue stalls the requester. A request is taken on any cycle with `req_valid && req_ready`, whether it is accepted or refused. While `req_valid` is high, `cmd_valid` is high exactly when the request would be accepted. The acknowledge and completion-result outputs are single-cycle pulses with no ready, so the requester must sample them. Completions are always taken.

Top module: `inflight_line_tracker`

## Requirements
- R1: Kinds are encoded on `req_kind` as load=0, fetch=1, store=2, rmw-read=3, rmw-write=4, locked-read=5, locked-write=6. Kinds 0 and 1 enter the read table (completion with `cpl_wtab`=0). All other kinds enter the write table (`cpl_wtab`=1).
- R2: A request whose line (address bits above the offset) matches a live entry of either table is refused with status 1 (alias). It is not inserted and raises no `cmd_valid`.
- R3: Without an alias, a request is refused with status 2 (full) in either of two cases. The first is that the total outstanding count is at or above `MAX_OUT`. The second is that its target table has no free entry.
- R4: A request whose offset plus `req_len` exceeds `LINE_BYTES` is refused with status 4 (span). Span takes priority over alias, then full, then store-conditional failure. A span ending exactly at the line end is accepted.
- R5: A locked-write whose line is not covered by the held reservation is refused with status 3 (conditional fail) and issues no command. When the reservation covers its line, the locked-write is accepted and the reservation is cleared.
- R6: A completion that frees a locked-read entry from the write table sets the reservation to that line.
- R7: `cmd_code` is load=0, store=1, fetch=2, atomic=3. All four rmw and locked kinds give atomic.
- R8: `req_mode` is user=0, supervisor=1, device=2. `cmd_priv` is 1 only for supervisor, so device is encoded as user.
- R9: The outstanding count always equals the read-table occupancy plus the write-table occupancy. It never exceeds `MAX_OUT`.
- R10: Accepted requests receive sequence numbers 0, 1, 2, and so on, in order. Refused requests consume none. A refusal acknowledges with number 0.
- R11: One cycle after `cpl_valid`, `done_valid` pulses. If the named table held the line, `done_id` carries that entry's sequence number and `done_err`=0. Otherwise `done_err`=1.
- R12: `deadlock` latches high once any live entry has been outstanding for `DEADLOCK_CYC` cycles. It stays low while entries are completed sooner or none are live.
- R13: `req_ready` equals `cmd_ready`. `ack_valid` pulses one cycle after each taken request, and never after a cycle in which the request was not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with valid |
| req_kind | input | 3 | Request kind |
| req_mode | input | 2 | Access mode |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count |
| cmd_valid | output | 1 | Cache command present |
| cmd_ready | input | 1 | Cache queue can take a command |
| cmd_code | output | 2 | Cache command code |
| cmd_priv | output | 1 | Supervisor access |
| cmd_line | output | LINE_W | Line address |
| cmd_addr | output | ADDR_W | Byte address |
| cmd_len | output | LEN_W | Byte count |
| ack_valid | output | 1 | Request result pulse |
| ack_status | output | 3 | Result status |
| ack_id | output | ID_W | Sequence number of an accepted request |
| cpl_valid | input | 1 | Completion present |
| cpl_wtab | input | 1 | Completion targets the write table |
| cpl_line | input | LINE_W | Completed line address |
| done_valid | output | 1 | Completion result pulse |
| done_id | output | ID_W | Sequence number of the freed entry |
| done_err | output | 1 | No matching entry found |
| deadlock | output | 1 | Sticky age-limit flag |

## Verification
The bench builds the block with 4 entries per table, an outstanding limit of 6 and an age limit of 64 cycles. With 6 requests in flight, the count limit refuses a seventh request even though the read table is full and the write table still has room. Four stores alone fill the write table while the count is still below 6, so the table-full refusal is reached separately from the count limit. The 64-cycle limit is long enough to finish every other scenario without tripping, yet short enough for the final scenario to hold one load past it.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_FETCH  = 3'd1,
    K_STORE  = 3'd2,
    K_RMW_RD = 3'd3,
    K_RMW_WR = 3'd4,
    K_LK_RD  = 3'd5,
    K_LK_WR  = 3'd6
  } kind_e;

  typedef enum logic [1:0] {
    C_LOAD   = 2'd0,
    C_STORE  = 2'd1,
    C_FETCH  = 2'd2,
    C_ATOMIC = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    S_OK     = 3'd0,
    S_ALIAS  = 3'd1,
    S_FULL   = 3'd2,
    S_SCFAIL = 3'd3,
    S_SPAN   = 3'd4
  } stat_e;

  localparam logic [1:0] M_USER   = 2'd0;
  localparam logic [1:0] M_SUPER  = 2'd1;
  localparam logic [1:0] M_DEVICE = 2'd2;

  // Loads and fetches are tracked as reads; everything else as writes.
  function automatic logic goes_to_wtab(input logic [2:0] k);
    return !((k == K_LOAD) || (k == K_FETCH));
  endfunction

endpackage

// File: rtl/lt_line_table.sv
module lt_line_table #(
  parameter int ENTRIES = 8,
  parameter int LINE_W  = 26,
  parameter int ID_W    = 8,
  parameter int TS_W    = 16,
  parameter int OCC_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic              alloc_flag,
  input  logic [TS_W-1:0]   now,
  input  logic              rel_en,
  input  logic [LINE_W-1:0] rel_line,
  output logic              rel_hit,
  output logic [ID_W-1:0]   rel_id,
  output logic              rel_flag,
  output logic              has_free,
  output logic [OCC_W-1:0]  occ,
  input  logic [TS_W-1:0]   limit,
  output logic              stale
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ID_W-1:0]    id_q   [ENTRIES];
  logic               flag_q [ENTRIES];
  logic [TS_W-1:0]    ts_q   [ENTRIES];

  logic [ENTRIES-1:0] look_m, rel_m, stale_m;
  logic [IDX_W-1:0]   free_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [TS_W-1:0] age;
    assign age        = now - ts_q[g];
    assign look_m[g]  = vld[g] && (line_q[g] == look_line);
    assign rel_m[g]   = vld[g] && (line_q[g] == rel_line);
    assign stale_m[g] = vld[g] && (age >= limit);
  end

  assign look_hit = |look_m;
  assign rel_hit  = |rel_m;
  assign stale    = |stale_m;
  assign occ      = OCC_W'($countones(vld));

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rel_id   = '0;
    rel_flag = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rel_m[i]) begin
        rel_id   = rel_id | id_q[i];
        rel_flag = rel_flag | flag_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rel_en && rel_m[i]) vld[i] <= 1'b0;
        if (alloc_en && has_free && (free_idx == IDX_W'(i))) begin
          vld[i]    <= 1'b1;
          line_q[i] <= alloc_line;
          id_q[i]   <= alloc_id;
          flag_q[i] <= alloc_flag;
          ts_q[i]   <= now;
        end
      end
    end
  end

endmodule

// File: rtl/lt_cmd_encoder.sv
module lt_cmd_encoder
  import lt_pkg::*;
(
  input  logic [2:0] kind,
  input  logic [1:0] mode,
  output logic [1:0] code,
  output logic       priv
);

  always_comb begin
    case (kind)
      K_LOAD:  code = C_LOAD;
      K_FETCH: code = C_FETCH;
      K_STORE: code = C_STORE;
      default: code = C_ATOMIC;
    endcase
    priv = (mode == M_SUPER);
  end

endmodule

// File: rtl/inflight_line_tracker.sv
module inflight_line_tracker
  import lt_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int ENTRIES      = 8,
  parameter int MAX_OUT      = 12,
  parameter int ID_W         = 8,
  parameter int TS_W         = 16,
  parameter int DEADLOCK_CYC = 1000,
  localparam int OFF_W       = $clog2(LINE_BYTES),
  localparam int LINE_W      = ADDR_W - OFF_W,
  localparam int LEN_W       = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_code,
  output logic              cmd_priv,
  output logic [LINE_W-1:0] cmd_line,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              ack_valid,
  output logic [2:0]        ack_status,
  output logic [ID_W-1:0]   ack_id,
  input  logic              cpl_valid,
  input  logic              cpl_wtab,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic              done_err,
  output logic              deadlock
);

  localparam int OCC_W = $clog2(ENTRIES + 1);
  localparam int CNT_W = $clog2(2 * ENTRIES + 1);

  logic [LINE_W-1:0] req_line;
  logic [OFF_W-1:0]  req_off;
  logic [LEN_W:0]    span_end;
  logic              span_bad, to_w, alias_hit, no_room, res_match, accept, fire;
  logic [2:0]        status;

  logic              rd_hit, wr_hit, rd_free, wr_free, rd_stale, wr_stale;
  logic              rd_rel_hit, wr_rel_hit, rd_rel_flag, wr_rel_flag;
  logic [ID_W-1:0]   rd_rel_id, wr_rel_id;
  logic [OCC_W-1:0]  rd_occ, wr_occ;
  logic              cpl_hit, cpl_flag;
  logic [ID_W-1:0]   cpl_id;

  logic [CNT_W-1:0]  outstanding;
  logic [ID_W-1:0]   next_id;
  logic [TS_W-1:0]   now;
  logic              res_vld;
  logic [LINE_W-1:0] res_line;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign span_end = (LEN_W+1)'(req_off) + (LEN_W+1)'(req_len);
  assign span_bad = span_end > (LEN_W+1)'(LINE_BYTES);

  assign to_w      = goes_to_wtab(req_kind);
  assign alias_hit = rd_hit || wr_hit;
  assign no_room   = (outstanding >= CNT_W'(MAX_OUT)) || (to_w ? !wr_free : !rd_free);
  assign res_match = res_vld && (res_line == req_line);

  always_comb begin
    if (span_bad)                                 status = S_SPAN;
    else if (alias_hit)                           status = S_ALIAS;
    else if (no_room)                             status = S_FULL;
    else if ((req_kind == K_LK_WR) && !res_match) status = S_SCFAIL;
    else                                          status = S_OK;
  end

  assign req_ready = cmd_ready;
  assign fire      = req_valid && req_ready;
  assign accept    = fire && (status == S_OK);
  assign cmd_valid = req_valid && (status == S_OK);
  assign cmd_line  = req_line;
  assign cmd_addr  = req_addr;
  assign cmd_len   = req_len;

  lt_cmd_encoder u_enc (
    .kind (req_kind),
    .mode (req_mode),
    .code (cmd_code),
    .priv (cmd_priv)
  );

  lt_line_table #(
    .ENTRIES (ENTRIES), .LINE_W (LINE_W), .ID_W (ID_W), .TS_W (TS_W), .OCC_W (OCC_W)
  ) u_rd_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_line  (req_line),
    .look_hit   (rd_hit),
    .alloc_en   (accept && !to_w),
    .alloc_line (req_line),
    .alloc_id   (next_id),
    .alloc_flag (1'b0),
    .now        (now),
    .rel_en     (cpl_valid && !cpl_wtab),
    .rel_line   (cpl_line),
    .rel_hit    (rd_rel_hit),
    .rel_id     (rd_rel_id),
    .rel_flag   (rd_rel_flag),
    .has_free   (rd_free),
    .occ        (rd_occ),
    .limit      (TS_W'(DEADLOCK_CYC)),
    .stale      (rd_stale)
  );

  lt_line_table #(
    .ENTRIES (ENTRIES), .LINE_W (LINE_W), .ID_W (ID_W), .TS_W (TS_W), .OCC_W (OCC_W)
  ) u_wr_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_line  (req_line),
    .look_hit   (wr_hit),
    .alloc_en   (accept && to_w),
    .alloc_line (req_line),
    .alloc_id   (next_id),
    .alloc_flag (req_kind == K_LK_RD),
    .now        (now),
    .rel_en     (cpl_valid && cpl_wtab),
    .rel_line   (cpl_line),
    .rel_hit    (wr_rel_hit),
    .rel_id     (wr_rel_id),
    .rel_flag   (wr_rel_flag),
    .has_free   (wr_free),
    .occ        (wr_occ),
    .limit      (TS_W'(DEADLOCK_CYC)),
    .stale      (wr_stale)
  );

  assign cpl_hit  = cpl_wtab ? wr_rel_hit  : rd_rel_hit;
  assign cpl_id   = cpl_wtab ? wr_rel_id   : rd_rel_id;
  assign cpl_flag = cpl_wtab ? wr_rel_flag : rd_rel_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      next_id     <= '0;
      now         <= '0;
      res_vld     <= 1'b0;
      res_line    <= '0;
      ack_valid   <= 1'b0;
      ack_status  <= '0;
      ack_id      <= '0;
      done_valid  <= 1'b0;
      done_id     <= '0;
      done_err    <= 1'b0;
      deadlock    <= 1'b0;
    end else begin
      now         <= now + 1'b1;
      outstanding <= outstanding + CNT_W'(accept) - CNT_W'(cpl_valid && cpl_hit);
      if (accept) next_id <= next_id + 1'b1;

      // Consuming a reservation comes first; a fresh one set this cycle wins.
      if (accept && (req_kind == K_LK_WR)) res_vld <= 1'b0;
      if (cpl_valid && cpl_wtab && cpl_hit && cpl_flag) begin
        res_vld  <= 1'b1;
        res_line <= cpl_line;
      end

      ack_valid  <= fire;
      ack_status <= status;
      ack_id     <= accept ? next_id : '0;

      done_valid <= cpl_valid;
      done_id    <= (cpl_valid && cpl_hit) ? cpl_id : '0;
      done_err   <= cpl_valid && !cpl_hit;

      if (rd_stale || wr_stale) deadlock <= 1'b1;
    end
  end

endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
  parameter int MAX_OUT = 12,
  parameter int CNT_W   = 5,
  parameter int OCC_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_kind,
  input logic [1:0]       req_mode,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_code,
  input logic             cmd_priv,
  input logic             ack_valid,
  input logic [2:0]       ack_status,
  input logic             deadlock,
  input logic [CNT_W-1:0] outstanding,
  input logic [OCC_W-1:0] rd_occ,
  input logic [OCC_W-1:0] wr_occ
);

  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) == 32'(rd_occ) + 32'(wr_occ)); // R9

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) <= MAX_OUT); // R9

  AST_ACK_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(req_valid && req_ready)); // R13

  AST_CMD_ACK_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (ack_valid && ack_status == 3'd0)); // R2

  AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> req_valid); // R13

  AST_ATOMIC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && req_kind >= 3'd3) |-> (cmd_code == 2'd3)); // R7

  AST_DEVICE_AS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && req_mode == 2'd2) |-> !cmd_priv); // R8

  AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock); // R12

endmodule

bind inflight_line_tracker lt_checker #(
  .MAX_OUT (MAX_OUT), .CNT_W (CNT_W), .OCC_W (OCC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .req_mode    (req_mode),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_code    (cmd_code),
  .cmd_priv    (cmd_priv),
  .ack_valid   (ack_valid),
  .ack_status  (ack_status),
  .deadlock    (deadlock),
  .outstanding (outstanding),
  .rd_occ      (rd_occ),
  .wr_occ      (wr_occ)
);

// File: tb/test_inflight_line_tracker.sv
module test_inflight_line_tracker;

  localparam int AW = 32, LB = 64, LW = 26, LNW = 7, IW = 8;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, cmd_ready = 1, cpl_valid = 0, cpl_wtab = 0;
  logic [2:0]    req_kind = 0;
  logic [1:0]    req_mode = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LNW-1:0] req_len = 1;
  logic [LW-1:0] cpl_line = 0;
  logic          req_ready, cmd_valid, cmd_priv, ack_valid, done_valid, done_err, deadlock;
  logic [1:0]    cmd_code;
  logic [LW-1:0] cmd_line;
  logic [AW-1:0] cmd_addr;
  logic [LNW-1:0] cmd_len;
  logic [2:0]    ack_status;
  logic [IW-1:0] ack_id, done_id;

  int total = 0, bad = 0, exp_id = 0;

  always #10 clk = ~clk;

  inflight_line_tracker #(
    .ADDR_W (AW), .LINE_BYTES (LB), .ENTRIES (4), .MAX_OUT (6),
    .ID_W (IW), .TS_W (16), .DEADLOCK_CYC (64)
  ) i_inflight_line_tracker (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Statuses: 0 ok, 1 alias, 2 full, 3 cond fail, 4 span.
  task automatic issue(input [2:0] k, input [1:0] m, input [31:0] a, input [6:0] l,
                       input [2:0] st, input [1:0] code, input bit pv, input string tag);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_mode = m; req_addr = a; req_len = l;
    #1;
    chk(cmd_valid == (st == 0), {tag, " cmd_valid"}, cmd_valid, st == 0);
    if (st == 0) begin
      chk(cmd_code == code, {tag, " cmd_code"}, cmd_code, code);
      chk(cmd_priv == pv, {tag, " cmd_priv"}, cmd_priv, pv);
    end
    @(negedge clk);
    req_valid = 0;
    chk(ack_valid && ack_status == st, {tag, " status"}, ack_status, st);
    if (st == 0) begin
      chk(ack_id == IW'(exp_id), {tag, " id"}, ack_id, exp_id);
      exp_id++;
    end else chk(ack_id == 0, {tag, " refused id"}, ack_id, 0);
  endtask

  task automatic complete(input bit w, input [31:0] a, input bit err, input int id,
                          input string tag);
    @(negedge clk);
    cpl_valid = 1; cpl_wtab = w; cpl_line = a[31:6];
    @(negedge clk);
    cpl_valid = 0;
    chk(done_valid && done_err == err, {tag, " done_err"}, done_err, err);
    if (!err) chk(done_id == IW'(id), {tag, " done_id"}, done_id, id);
  endtask

  task automatic t_reset;
    chk(!ack_valid && !done_valid && !deadlock, "R13 reset outputs", ack_valid, 0);
    chk(req_ready == 1, "R13 ready follows cmd_ready", req_ready, 1);
  endtask

  task automatic t_basic;
    issue(0, 0, 32'h040, 4, 0, 0, 0, "R7 load");             // id0 rd A
    issue(2, 1, 32'h080, 8, 0, 1, 1, "R8 store supervisor"); // id1 wr B
    issue(0, 0, 32'h048, 4, 1, 0, 0, "R2 alias read line");
    issue(0, 0, 32'h084, 4, 1, 0, 0, "R2 alias write line");
    issue(1, 2, 32'h0C0, 4, 0, 2, 0, "R8 fetch device");     // id2 rd C
    issue(0, 0, 32'h13C, 8, 4, 0, 0, "R4 span over edge");
    issue(0, 0, 32'h138, 8, 0, 0, 0, "R4 span to edge");     // id3 rd D
    issue(3, 0, 32'h140, 4, 0, 3, 0, "R7 rmw read atomic");  // id4 wr E
    issue(0, 0, 32'h180, 4, 0, 0, 0, "R1 load fills rd");    // id5 rd F
    issue(2, 0, 32'h1C0, 4, 2, 0, 0, "R3 count limit");
  endtask

  task automatic t_complete;
    complete(0, 32'h040, 0, 0, "R11 read A");
    complete(1, 32'h040, 1, 0, "R11 A gone");
    complete(0, 32'h080, 1, 0, "R1 store not in rd table");
    complete(1, 32'h080, 0, 1, "R1 store in wr table");
    complete(0, 32'h0C0, 0, 2, "R1 fetch in rd table");
    complete(0, 32'h100, 0, 3, "R10 id echo D");
    complete(1, 32'h140, 0, 4, "R1 rmw in wr table");
    complete(0, 32'h180, 0, 5, "R10 id echo F");
  endtask

  task automatic t_table_full;
    for (int i = 0; i < 4; i++)
      issue(2, 0, 32'h400 + 32'(i) * 64, 4, 0, 1, 0, "R3 fill wr table");
    issue(4, 0, 32'h600, 4, 2, 0, 0, "R3 wr table full");
    issue(0, 0, 32'h640, 4, 0, 0, 0, "R3 rd still free");
    for (int i = 0; i < 4; i++)
      complete(1, 32'h400 + 32'(i) * 64, 0, 6 + i, "R10 drain wr");
    complete(0, 32'h640, 0, 10, "R10 drain rd");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    cmd_ready = 0; req_valid = 1; req_kind = 0; req_addr = 32'h700; req_len = 4;
    #1 chk(req_ready == 0, "R13 ready low", req_ready, 0);
    @(negedge clk);
    chk(ack_valid == 0, "R13 no ack when stalled", ack_valid, 0);
    req_valid = 0; cmd_ready = 1;
    issue(0, 0, 32'h700, 4, 0, 0, 0, "R13 after stall");
    complete(0, 32'h700, 0, exp_id - 1, "R13 drain");
  endtask

  task automatic t_llsc;
    issue(6, 0, 32'h800, 4, 3, 0, 0, "R5 no reservation");
    issue(5, 0, 32'h800, 4, 0, 3, 0, "R7 locked read atomic");
    complete(0, 32'h800, 1, 0, "R1 locked read not in rd");
    complete(1, 32'h800, 0, exp_id - 1, "R6 locked read done");
    issue(6, 0, 32'h840, 4, 3, 0, 0, "R5 other line refused");
    issue(6, 0, 32'h800, 4, 0, 3, 0, "R6 reserved write ok");
    complete(1, 32'h800, 0, exp_id - 1, "R5 locked write done");
    issue(6, 0, 32'h800, 4, 3, 0, 0, "R5 reservation consumed");
    issue(4, 0, 32'h880, 4, 0, 3, 0, "R7 rmw write atomic");
    complete(1, 32'h880, 0, exp_id - 1, "R1 rmw write in wr");
  endtask

  task automatic t_watchdog;
    chk(deadlock == 0, "R12 quiet before", deadlock, 0);
    issue(0, 0, 32'h900, 4, 0, 0, 0, "R12 load");
    repeat (40) @(negedge clk);
    chk(deadlock == 0, "R12 under limit", deadlock, 0);
    repeat (40) @(negedge clk);
    chk(deadlock == 1, "R12 over limit", deadlock, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_complete();
    t_table_full();
    t_backpressure();
    t_llsc();
    t_watchdog();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule